// File: doc/BRIEF.md
# Packed Quadword Logical Right Shifter

This execution unit takes a 128-bit vector operand and treats it as two separate 64-bit lanes. Both lanes are shifted right logically by one shared count. Zeros fill the vacated high bits of each lane. The 128-bit result is written back in place of the first operand, so the destination and the first source are the same register.

The count has two possible sources. A small front end matches fixed instruction bytes to decide which one applies. In the vector-count form, the count is the full low 64-bit half of a second 128-bit operand. In the immediate form, it is an unsigned 8-bit immediate byte. Any count above 63 clears both lanes; the count is not taken modulo 64.

Inputs are taken on a clock edge while `in_valid` is high. One clock later the result appears with `out_valid`. If the bytes match neither encoding, the unit pulses `illegal` instead and the result register keeps its old value. Reset is asynchronous and active-low, and its release is synchronised internally.

Top module: `pqsr_unit`

## Requirements
- R1: Bits 127:64 and 63:0 of `src_a` are two independent lanes. Each lane is shifted right by the same count, and no bit crosses from the upper lane into the lower lane.
- R2: The shift is logical: every vacated high bit of a lane becomes 0, whatever the lane's sign bit was.
- R3: In the vector-count form, all 64 bits of `src_b[63:0]` form the count. Any value above 63 (for example 0x40, 0x100 or 2^63) makes the whole 128-bit result zero.
- R4: In the immediate form, the count is the unsigned byte `insn[39:32]`. Immediate values 64 through 255 make the result zero.
- R5: The vector-count form is selected when `insn[7:0]`=0x66, `insn[15:8]`=0x0F and `insn[23:16]`=0xD3. The ModRM byte `insn[31:24]` may hold any value.
- R6: The immediate form is selected when `insn[7:0]`=0x66, `insn[15:8]`=0x0F and `insn[23:16]`=0x73, and the ModRM reg field `insn[29:27]` equals 2.
- R7: In the vector-count form, `src_b[127:64]` has no effect on the result. In the immediate form, all of `src_b` has no effect.
- R8: A count of 0 passes both lanes through unchanged. A count of 63 leaves only the former bit 63 of each lane in bit 0, and the rest of the lane is zero.
- R9: A legal operation taken with `in_valid` high produces `out_valid`=1 and the new `result` exactly one clock later. In any cycle that follows a clock with `in_valid` low, `out_valid` and `illegal` are both low and `result` holds its value.
- R10: When `in_valid` is high and the bytes match neither form, `illegal` is 1 for exactly the following cycle, `out_valid` is 0, and `result` holds its previous value.
- R11: While reset is asserted, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| insn | input | 40 | Instruction bytes, byte 0 in bits 7:0 |
| src_a | input | 128 | First source, two 64-bit lanes |
| src_b | input | 128 | Second source; low half gives the vector-form count |
| out_valid | output | 1 | Result register updated by a legal operation |
| illegal | output | 1 | Previous operation matched no encoding |
| result | output | 128 | Shifted value that replaces the first operand |

## Verification
Every output is due one clock edge after the cycle that drives its stimulus. This applies to `out_valid`, `illegal` and `result`, because each of them passes through a single register. The bench drives inputs on the falling edge. Its behavioural reference updates right after the next rising edge, and the design outputs are compared with it 1 ns later on every step. Idle and illegal steps check that the result still equals the last legal value.

// File: rtl/pqsr_pkg.sv
package pqsr_pkg;

  localparam int unsigned BYTE_W = 8;

  // Fixed bytes matched by the front end
  localparam logic [7:0] PFX_OPSIZE = 8'h66;
  localparam logic [7:0] ESC_TWO    = 8'h0F;
  localparam logic [7:0] OPC_VEC    = 8'hD3;
  localparam logic [7:0] OPC_GRP    = 8'h73;
  localparam logic [2:0] GRP_SRLQ   = 3'd2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_VEC  = 2'd1,
    OP_IMM  = 2'd2
  } op_kind_e;

endpackage

// File: rtl/pqsr_rst_sync.sv
module pqsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pqsr_decode.sv
module pqsr_decode
  import pqsr_pkg::*;
#(
  parameter int unsigned INSN_BYTES = 5,
  parameter int unsigned IMM_W      = 8
) (
  input  logic [INSN_BYTES*BYTE_W-1:0] insn,
  output op_kind_e                     kind,
  output logic [IMM_W-1:0]             imm
);

  localparam int unsigned MODRM_IDX = 3;
  localparam int unsigned IMM_IDX   = 4;

  logic [BYTE_W-1:0] byte_v [INSN_BYTES];
  logic              head_ok;
  logic [2:0]        modrm_reg;
  logic              unused_modrm;

  genvar gi;
  generate
    for (gi = 0; gi < INSN_BYTES; gi++) begin : g_bytes
      assign byte_v[gi] = insn[gi*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign modrm_reg    = byte_v[MODRM_IDX][5:3];
  assign unused_modrm = ^{byte_v[MODRM_IDX][7:6], byte_v[MODRM_IDX][2:0]};
  assign head_ok      = (byte_v[0] == PFX_OPSIZE) && (byte_v[1] == ESC_TWO);

  always_comb begin
    kind = OP_NONE;
    if (head_ok) begin
      if (byte_v[2] == OPC_VEC) begin
        kind = OP_VEC;
      end else if ((byte_v[2] == OPC_GRP) && (modrm_reg == GRP_SRLQ)) begin
        kind = OP_IMM;
      end
    end
  end

  assign imm = byte_v[IMM_IDX][IMM_W-1:0];

endmodule

// File: rtl/pqsr_count_sel.sv
module pqsr_count_sel
  import pqsr_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned LANE_W = 64
) (
  input  op_kind_e                      kind,
  input  logic [CNT_W-1:0]              vec_cnt,
  input  logic [IMM_W-1:0]              imm,
  output logic [$clog2(LANE_W)-1:0]     sh_amt,
  output logic                          oversize
);

  localparam int unsigned SH_W = $clog2(LANE_W);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (kind)
      OP_IMM:  cnt = {{(CNT_W-IMM_W){1'b0}}, imm};
      default: cnt = vec_cnt;
    endcase
  end

  // Any set bit at or above the lane width means a count past the lane
  assign sh_amt   = cnt[SH_W-1:0];
  assign oversize = |cnt[CNT_W-1:SH_W];

endmodule

// File: rtl/pqsr_lane.sv
module pqsr_lane #(
  parameter int unsigned LANE_W = 64
) (
  input  logic [LANE_W-1:0]         din,
  input  logic [$clog2(LANE_W)-1:0] sh_amt,
  input  logic                      zero,
  output logic [LANE_W-1:0]         dout
);

  localparam int unsigned SH_W = $clog2(LANE_W);

  logic [LANE_W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  genvar s;
  generate
    for (s = 0; s < SH_W; s++) begin : g_stage
      assign stg[s+1] = sh_amt[s] ? (stg[s] >> (2**s)) : stg[s];
    end
  endgenerate

  assign dout = zero ? '0 : stg[SH_W];

endmodule

// File: rtl/pqsr_unit.sv
module pqsr_unit
  import pqsr_pkg::*;
#(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned LANES  = 2,
  parameter int unsigned IMM_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [39:0]               insn,
  input  logic [LANES*LANE_W-1:0]   src_a,
  input  logic [LANES*LANE_W-1:0]   src_b,
  output logic                      out_valid,
  output logic                      illegal,
  output logic [LANES*LANE_W-1:0]   result
);

  localparam int unsigned VEC_W = LANES * LANE_W;
  localparam int unsigned CNT_W = LANE_W;
  localparam int unsigned SH_W  = $clog2(LANE_W);

  logic              rst_sync_n;
  op_kind_e          kind;
  logic [IMM_W-1:0]  imm;
  logic [SH_W-1:0]   sh_amt;
  logic              cnt_oversize;
  logic [VEC_W-1:0]  shifted;
  logic              unused_hi;

  logic              valid_d, valid_q;
  logic              illegal_d, illegal_q;
  logic              result_en;
  logic [VEC_W-1:0]  result_q;

  assign unused_hi = ^src_b[VEC_W-1:CNT_W];

  pqsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pqsr_decode #(.INSN_BYTES(5), .IMM_W(IMM_W)) u_dec (
    .insn (insn),
    .kind (kind),
    .imm  (imm)
  );

  pqsr_count_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W), .LANE_W(LANE_W)) u_cnt (
    .kind     (kind),
    .vec_cnt  (src_b[CNT_W-1:0]),
    .imm      (imm),
    .sh_amt   (sh_amt),
    .oversize (cnt_oversize)
  );

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_lane
      pqsr_lane #(.LANE_W(LANE_W)) u_lane (
        .din    (src_a[li*LANE_W +: LANE_W]),
        .sh_amt (sh_amt),
        .zero   (cnt_oversize),
        .dout   (shifted[li*LANE_W +: LANE_W])
      );
    end
  endgenerate

  // Next-state
  always_comb begin
    valid_d   = in_valid && (kind != OP_NONE);
    illegal_d = in_valid && (kind == OP_NONE);
    result_en = valid_d;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      if (result_en) begin
        result_q <= shifted;
      end
    end
  end

  assign out_valid = valid_q;
  assign illegal   = illegal_q;
  assign result    = result_q;

endmodule

// File: rtl/pqsr_unit_chk.sv
module pqsr_unit_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             in_valid,
  input logic             oversize,
  input logic             out_valid,
  input logic             illegal,
  input logic [VEC_W-1:0] result
);

  // R9: no output activity after an idle input cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(in_valid) |-> (!out_valid && !illegal));

  // R10: a cycle is never both legal and illegal
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !(out_valid && illegal));

  // R9, R10: result only moves with out_valid
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !out_valid |-> $stable(result));

  // R3, R4: oversize count clears both lanes
  p_oversize_zero_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(in_valid && oversize) && out_valid) |-> (result == '0));

endmodule

bind pqsr_unit pqsr_unit_chk #(.VEC_W(LANES*LANE_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .in_valid  (in_valid),
  .oversize  (cnt_oversize),
  .out_valid (out_valid),
  .illegal   (illegal),
  .result    (result)
);

// File: tb/pqsr_unit_test.sv
`timescale 1ns/1ps
module pqsr_unit_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [39:0]  insn;
  logic [127:0] src_a, src_b;
  logic         out_valid, illegal;
  logic [127:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic         ev, ei;
  logic [127:0] er;

  always #2 clk = ~clk;

  pqsr_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .illegal(illegal), .result(result)
  );

  function automatic logic [39:0] vec_insn(input logic [7:0] modrm);
    return {8'h00, modrm, 8'hD3, 8'h0F, 8'h66};
  endfunction

  function automatic logic [39:0] imm_insn(input logic [2:0] regf, input logic [7:0] ib);
    return {ib, 2'b11, regf, 3'b001, 8'h73, 8'h0F, 8'h66};
  endfunction

  function automatic bit ref_decode(input logic [39:0] ins, input logic [127:0] b,
                                    output longint unsigned cnt);
    cnt = 0;
    if (ins[7:0] != 8'h66 || ins[15:8] != 8'h0F) return 0;
    if (ins[23:16] == 8'hD3) begin cnt = b[63:0]; return 1; end
    if (ins[23:16] == 8'h73 && ins[29:27] == 3'd2) begin cnt = ins[39:32]; return 1; end
    return 0;
  endfunction

  function automatic logic [127:0] ref_shift(input logic [127:0] a, input longint unsigned c);
    logic [127:0] r;
    for (int l = 0; l < 2; l++) begin
      logic [63:0] lane;
      lane = a[l*64 +: 64];
      r[l*64 +: 64] = (c > 63) ? 64'd0 : (lane >> c);
    end
    return r;
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (out_valid !== ev || illegal !== ei || result !== er) begin
      n_fails++;
      $display("FAIL %s: got v=%b i=%b r=%h, want v=%b i=%b r=%h",
               tag, out_valid, illegal, result, ev, ei, er);
    end
  endtask

  task automatic step(input logic v, input logic [39:0] ins,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    longint unsigned c;
    bit ok;
    @(negedge clk);
    in_valid = v; insn = ins; src_a = a; src_b = b;
    @(posedge clk);
    #1;
    ok = ref_decode(ins, b, c);
    if (v && ok) begin ev = 1; ei = 0; er = ref_shift(a, c); end
    else if (v)  begin ev = 0; ei = 1; end
    else         begin ev = 0; ei = 0; end
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++; n_checks++;
      $display("FAIL watchdog: got hang, want completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  localparam logic [127:0] PAT = 128'hF0E1_D2C3_B4A5_9687_8123_4567_89AB_CDEF;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; src_a = '0; src_b = '0;
    ev = 0; ei = 0; er = '0;
    repeat (3) @(posedge clk);
    #1 check("R11 reset outputs");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R11 after release");

    step(1, vec_insn(8'hC1), PAT, 128'd4, "R1 R5 vec count 4");
    step(1, vec_insn(8'h00), PAT, 128'd0, "R8 count 0");
    step(1, vec_insn(8'hFF), {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
         128'd63, "R8 count 63");
    step(1, vec_insn(8'hC1), {128{1'b1}}, 128'd8, "R2 zero fill");
    step(1, vec_insn(8'hC1), PAT, 128'd64, "R3 count 64");
    step(1, vec_insn(8'hC1), PAT, 128'h100, "R3 count 0x100");
    step(1, vec_insn(8'hC1), PAT, {64'd0, 64'h8000_0000_0000_0000}, "R3 count 2^63");
    step(1, vec_insn(8'hC1), PAT, {64'hFFFF_FFFF_FFFF_FFFF, 64'd5}, "R7 upper src_b ignored");
    step(1, imm_insn(3'd2, 8'd12), PAT, 128'd0, "R4 R6 imm 12");
    step(1, imm_insn(3'd2, 8'd63), PAT, 128'd0, "R4 R8 imm 63");
    step(1, imm_insn(3'd2, 8'd1), PAT, {128{1'b1}}, "R7 imm ignores src_b");
    step(1, imm_insn(3'd2, 8'd64), PAT, 128'd1, "R4 imm 64");
    step(1, imm_insn(3'd2, 8'd3), PAT, 128'd0, "R1 refill");
    step(1, imm_insn(3'd2, 8'd255), PAT, 128'd0, "R4 imm 255");
    step(1, vec_insn(8'h11), PAT, 128'd17, "R5 any modrm");
    step(1, imm_insn(3'd3, 8'd4), ~PAT, 128'd2, "R6 R10 wrong reg field");
    step(0, vec_insn(8'hC1), ~PAT, 128'd1, "R9 idle holds");
    step(1, {8'h00, 8'hC1, 8'hD3, 8'h0F, 8'h67}, ~PAT, 128'd1, "R5 R10 bad prefix");
    step(1, {8'h00, 8'hC1, 8'hD2, 8'h0F, 8'h66}, ~PAT, 128'd1, "R10 bad opcode");
    step(0, '0, '0, '0, "R10 pulse ends");
    step(1, vec_insn(8'hC1), {64'h0000_0000_0000_0001, 64'hFFFF_0000_0000_0000},
         128'd1, "R1 lanes isolated");
    step(1, vec_insn(8'hC1), ~PAT, 128'd33, "R9 back to back");
    step(0, '0, '0, '0, "R9 valid drops");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule